// File: doc/BRIEF.md
# Carry-Chained Additive Word Scrambler

This block scrambles a stream of narrow message words by adding a fixed key to each one. Every accepted message word is zero-extended by one bit and summed with a constant key register and a stored carry bit. The low bits of that sum become the scrambled output word. The carry out is kept and folded into the next accepted word, so each output depends on the whole history of words since the last initialisation. The block acts as an integrator over the word stream.

A receiver undoes the scrambling by subtracting the same key with a matching carry. Both ends must start from the same state, so the block has a synchronous initialise input that reloads the key and clears the carry. It also has an active-low asynchronous reset that does the same. Output valid follows input valid one cycle later. Idle cycles leave the state untouched.

Top module: `chained_scrambler`

## Requirements
- R1: After rst_ni is released and before any word is accepted, valid_o is 0, word_o is 0, and the stored carry is 0.
- R2: For an accepted word (valid_i=1, init_i=0), the next cycle shows word_o = (msg_i + key + carry) mod 2^18, where msg_i is taken as unsigned with a zero bit added above bit 16.
- R3: Bit 18 of that 19-bit sum is stored as the carry and is added to the next accepted word only.
- R4: valid_o is 1 in the cycle after a cycle with valid_i=1 and init_i=0, and 0 in every other cycle.
- R5: In a cycle with valid_i=0 and init_i=0, word_o and the stored carry keep their values, so a carry survives any number of idle cycles.
- R6: A cycle with init_i=1 clears the carry, drives word_o to 0 and valid_o to 0 on the next cycle, reloads the key, and ignores msg_i and valid_i in that cycle.
- R7: The key always equals the KEY_INIT parameter (default 223962) and is not changed by the data path. With carry 0, a zero message therefore returns the key itself.
- R8: From initialisation, the inputs 42, 24455, 48868, 73281, 97694 give 224004, 248417, 10686, 35100, 59513. The third word sets the carry, and the fourth and fifth words add it in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Synchronous initialise: clear carry, reload key |
| valid_i | input | 1 | Message word strobe |
| msg_i | input | 17 | Message word |
| valid_o | output | 1 | Scrambled word strobe |
| word_o | output | 18 | Scrambled word |

## Verification
The bound checker checks on every cycle that each accepted word yields the modular sum of message, key and stored carry. It also checks that the carry and output update together, that idle cycles freeze both, that valid is delayed by exactly one cycle, and that initialise clears state and the key never moves. Some behaviours show only across sequences of words, and those come from the bench scenarios. These are the known vector sequence with its carry crossing, a carry that survives a run of idle cycles, an initialise that lands mid-stream and drops a pending word, and long random streams compared against a bench model.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned MsgWDef   = 17;
  localparam int unsigned KeyInitDef = 223962;
endpackage

// File: rtl/scr_key_reg.sv
module scr_key_reg #(
  parameter int unsigned KEY_W    = 18,
  parameter int unsigned KEY_INIT = 223962
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  output logic [KEY_W-1:0] key_o
);
  localparam logic [KEY_W-1:0] KeyRst = KEY_W'(KEY_INIT);

  // key is loaded only by reset/init; data path never writes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     key_o <= KeyRst;
    else if (init_i) key_o <= KeyRst;
  end
endmodule

// File: rtl/scr_adder.sv
module scr_adder #(
  parameter int unsigned MSG_W = 17,
  parameter int unsigned KEY_W = 18
) (
  input  logic [MSG_W-1:0] msg_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             carry_i,
  output logic [KEY_W-1:0] sum_o,
  output logic             carry_o
);
  localparam int unsigned PadW = KEY_W - MSG_W + 1;
  localparam int unsigned SumW = KEY_W + 1;

  logic [SumW-1:0] msg_ext, key_ext, cin_ext, sum;

  always_comb begin
    msg_ext = {{PadW{1'b0}}, msg_i};
    key_ext = {1'b0, key_i};
    cin_ext = {{KEY_W{1'b0}}, carry_i};
    sum     = msg_ext + key_ext + cin_ext;
    sum_o   = sum[KEY_W-1:0];
    carry_o = sum[KEY_W];
  end
endmodule

// File: rtl/scr_state_reg.sv
module scr_state_reg #(
  parameter int unsigned KEY_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             valid_i,
  input  logic [KEY_W-1:0] sum_i,
  input  logic             carry_i,
  output logic [KEY_W-1:0] word_o,
  output logic             carry_o,
  output logic             valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      carry_o <= 1'b0;
      valid_o <= 1'b0;
    end else if (init_i) begin
      word_o  <= '0;
      carry_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        word_o  <= sum_i;
        carry_o <= carry_i;
      end
    end
  end
endmodule

// File: rtl/chained_scrambler.sv
module chained_scrambler #(
  parameter int unsigned MSG_W    = scr_pkg::MsgWDef,
  parameter int unsigned KEY_INIT = scr_pkg::KeyInitDef
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 init_i,
  input  logic                 valid_i,
  input  logic [MSG_W-1:0]     msg_i,
  output logic                 valid_o,
  output logic [MSG_W:0]       word_o
);
  localparam int unsigned KEY_W = MSG_W + 1;

  logic [KEY_W-1:0] key_q;
  logic [KEY_W-1:0] sum_d;
  logic             carry_d;
  logic             carry_q;

  scr_key_reg #(.KEY_W(KEY_W), .KEY_INIT(KEY_INIT)) u_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init_i),
    .key_o  (key_q)
  );

  scr_adder #(.MSG_W(MSG_W), .KEY_W(KEY_W)) u_add (
    .msg_i   (msg_i),
    .key_i   (key_q),
    .carry_i (carry_q),
    .sum_o   (sum_d),
    .carry_o (carry_d)
  );

  scr_state_reg #(.KEY_W(KEY_W)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (init_i),
    .valid_i (valid_i),
    .sum_i   (sum_d),
    .carry_i (carry_d),
    .word_o  (word_o),
    .carry_o (carry_q),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int unsigned MSG_W    = 17,
  parameter int unsigned KEY_W    = 18,
  parameter int unsigned KEY_INIT = 223962
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             init_i,
  input logic             valid_i,
  input logic [MSG_W-1:0] msg_i,
  input logic             valid_o,
  input logic [KEY_W-1:0] word_o,
  input logic [KEY_W-1:0] key_q,
  input logic             carry_q
);
  localparam logic [KEY_W-1:0] KeyRst = KEY_W'(KEY_INIT);

  // independent reference sum in the checker
  logic [KEY_W:0] ref_sum;
  always_comb
    ref_sum = (KEY_W+1)'(msg_i) + (KEY_W+1)'(key_q) + (KEY_W+1)'(carry_q);

  logic accept;
  always_comb accept = valid_i && !init_i;

  p_sum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (word_o == $past(ref_sum[KEY_W-1:0])));

  p_carry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (carry_q == $past(ref_sum[KEY_W])));

  p_valid_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> valid_o);

  p_valid_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !valid_o);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !init_i) |=> ($stable(word_o) && $stable(carry_q)));

  p_init_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (!carry_q && word_o == '0 && !valid_o));

  p_key_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_q == KeyRst);

  always @(negedge clk_i)
    if (rst_ni) p_no_x_r1: assert (!$isunknown({valid_o, word_o}));
endmodule

bind chained_scrambler scr_checker #(
  .MSG_W(MSG_W), .KEY_W(KEY_W), .KEY_INIT(KEY_INIT)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .init_i  (init_i),
  .valid_i (valid_i),
  .msg_i   (msg_i),
  .valid_o (valid_o),
  .word_o  (word_o),
  .key_q   (key_q),
  .carry_q (carry_q)
);

// File: tb/chained_scrambler_tb_top.sv
`timescale 1ns/1ps
module chained_scrambler_tb_top;
  localparam int unsigned MSG_W = 17;
  localparam int unsigned KEY_W = 18;
  localparam int unsigned KEY   = 223962;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             init_i = 1'b0;
  logic             valid_i = 1'b0;
  logic [MSG_W-1:0] msg_i = '0;
  logic             valid_o;
  logic [KEY_W-1:0] word_o;

  int checks = 0;
  int errors = 0;

  // bench model
  logic             m_carry = 1'b0;
  logic [KEY_W-1:0] m_word = '0;
  logic             m_valid = 1'b0;

  always #2.5 clk_i = ~clk_i;

  chained_scrambler dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .valid_i(valid_i),
    .msg_i(msg_i), .valid_o(valid_o), .word_o(word_o)
  );

  function automatic logic [KEY_W:0] model_sum(input logic [MSG_W-1:0] m, input logic c);
    return {2'b00, m} + 19'(KEY) + {18'd0, c};
  endfunction

  task automatic check(input string tag, input logic [KEY_W-1:0] act,
                       input logic [KEY_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at negedge, sample 1ns after the rising edge
  task automatic step(input logic v, input logic [MSG_W-1:0] m, input logic ini,
                      input string tag);
    logic [KEY_W:0] s;
    @(negedge clk_i);
    valid_i = v; msg_i = m; init_i = ini;
    @(posedge clk_i);
    #1;
    if (ini) begin
      m_carry = 1'b0; m_word = '0; m_valid = 1'b0;
    end else if (v) begin
      s = model_sum(m, m_carry);
      m_word = s[KEY_W-1:0]; m_carry = s[KEY_W]; m_valid = 1'b1;
    end else begin
      m_valid = 1'b0;
    end
    check({tag, " valid"}, KEY_W'(valid_o), KEY_W'(m_valid));
    check({tag, " word"}, word_o, m_word);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [MSG_W-1:0] vin[5];
    logic [KEY_W-1:0] vout[5];
    int seed;
    vin  = '{42, 24455, 48868, 73281, 97694};
    vout = '{224004, 248417, 10686, 35100, 59513};
    seed = 7;
    void'($urandom(seed));

    repeat (3) @(posedge clk_i);
    #1;
    check("R1 valid", KEY_W'(valid_o), '0);
    check("R1 word", word_o, '0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1 post-release word", word_o, '0);

    // R8 known sequence, checked against literal values
    for (int i = 0; i < 5; i++) begin
      step(1'b1, vin[i], 1'b0, "R8");
      check("R8 vector", word_o, vout[i]);
    end

    // R5 carry kept across idles; carry currently 1 after last vector
    for (int i = 0; i < 4; i++) step(1'b0, 17'h1ABCD, 1'b0, "R5 idle");
    check("R5 held word", word_o, vout[4]);
    step(1'b1, 17'd0, 1'b0, "R3");
    check("R3 carry added after idles", word_o, 18'(KEY + 1));

    // R6 init mid-stream drops the word in that cycle
    step(1'b1, 17'h1FFFF, 1'b0, "R2 max");
    step(1'b1, 17'd5, 1'b1, "R6 init");
    check("R6 word cleared", word_o, '0);
    // R7 zero message with cleared carry returns key
    step(1'b1, 17'd0, 1'b0, "R7");
    check("R7 key", word_o, 18'(KEY));

    // R2/R3 boundary: largest message twice, carry chain
    step(1'b1, 17'h1FFFF, 1'b0, "R2 max a");
    step(1'b1, 17'h1FFFF, 1'b0, "R3 max b");
    step(1'b0, 17'd0, 1'b0, "R4 gap");

    // random stream
    for (int i = 0; i < 400; i++) begin
      logic v, ini;
      logic [MSG_W-1:0] m;
      v   = ($urandom % 4) != 0;
      ini = ($urandom % 40) == 0;
      m   = MSG_W'($urandom);
      step(v, m, ini, "R2 rand");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule